// File: doc/BRIEF.md
# Write-Through Data Cache with Byte Parity and Refill-on-Error

This block is a direct-mapped, write-through data cache. It sits between a processor load/store port and a next-level memory port. Every store goes straight to the next level. A store that hits the cache also updates the cached word, so the cache never holds the only up-to-date copy of any data. That property lets the cache protect its contents with plain byte parity and no correcting code. When a load finds a parity mismatch on the word it reads, the line is dropped and fetched again from the next level, exactly as on an ordinary miss.

The processor side uses a valid/ready request handshake. Only one access is in flight at a time: the port drops ready from acceptance until it returns a one-cycle response pulse. The memory side issues two kinds of request. A line fill is a read at a line-aligned word address, answered by one beat per word in ascending order. A single-word write carries the store address and data. A small injection port flips one stored parity bit, so that fault recovery can be exercised. A saturating counter reports how many parity errors have been detected.

Top module: `wt_parity_cache`

## Requirements
- R1: After reset `cpuReqReady` is 1, `cpuRespValid` and `memReqValid` are 0, `errCount` is 0, and every line is invalid, so the first load of any address issues a fill.
- R2: A load hit returns the cached word with no next-level request, and `cpuRespValid` is high for exactly one cycle, the second cycle after the accepting edge.
- R3: A load miss issues one read request whose word address has its low log2(WORDS) bits zero. It then takes WORDS response beats in ascending word order and returns the beat of the requested word. Afterwards the line holds that tag.
- R4: A load never causes a next-level write, even when it replaces a valid line. Each access issues at most one fill request.
- R5: Every store, hit or miss, issues exactly one next-level write carrying the store's word address and data. The request is held stable until accepted, and the processor response follows acceptance.
- R6: A store hit updates the cached word, so a later load of that address hits and returns the new data.
- R7: A store miss does not allocate: a later load of the same address still misses and fills.
- R8: Each stored byte carries one even-parity bit. `faultValid` inverts the stored parity bit selected by `faultLine`, `faultWord` and `faultByte`, where `faultByte` 0 is bits 7:0. A load whose word shows any byte mismatch is treated as a miss: the line is refilled, the correct data is returned and `errCount` rises by one. Inverting the same bit twice restores a clean word.
- R9: Parity is checked only on the word being loaded. A fault in another word of the same line leaves a load hit unchanged.
- R10: A store hit recomputes the parity of the written word, which clears any fault injected into that word.
- R11: `errCount` increases by one per detected error and holds at its maximum value 2^ERR_CNT_W-1.
- R12: While an access is in flight, from the accepting edge until its response, `cpuReqReady` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuReqValid | input | 1 | Processor request valid |
| cpuReqReady | output | 1 | Cache can accept a request |
| cpuReqWrite | input | 1 | 1 = store, 0 = load |
| cpuReqAddr | input | ADDR_W | Word address |
| cpuReqWdata | input | DATA_W | Store data |
| cpuRespValid | output | 1 | One-cycle response pulse |
| cpuRespRdata | output | DATA_W | Load data, valid with the response of a load |
| memReqValid | output | 1 | Next-level request valid |
| memReqReady | input | 1 | Next level accepts the request |
| memReqWrite | output | 1 | 1 = word write, 0 = line fill |
| memReqAddr | output | ADDR_W | Word address (line-aligned for fills) |
| memReqWdata | output | DATA_W | Write data |
| memRespValid | input | 1 | Fill beat valid |
| memRespData | input | DATA_W | Fill beat data |
| faultValid | input | 1 | Invert one stored parity bit this cycle |
| faultLine | input | log2(LINES) | Line of the injected fault |
| faultWord | input | log2(WORDS) | Word of the injected fault |
| faultByte | input | log2(DATA_W/8) | Byte of the injected fault |
| errCount | output | ERR_CNT_W | Saturating parity-error count |

## Verification
The bench builds the cache with 16 lines of 4 words and 32-bit data. It narrows the address to 10 bits, which leaves a 4-bit tag, so a handful of addresses keep evicting one another and exercise replacement without writeback. The error counter is cut to 3 bits, which makes saturation reachable after seven detected faults. Next-level latency is varied between accesses, so fills and writes are seen both under back-pressure and with immediate acceptance.

// File: rtl/wtc_pkg.sv
package wtc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_WR_REQ,
    ST_FILL_REQ,
    ST_FILL_WAIT,
    ST_RESP
  } wtcState_e;

  // Strobes from control to datapath, one per datapath action.
  typedef struct packed {
    logic latchReq;     // capture the accepted processor request
    logic storeUpdate;  // write the store word and its parity into the line
    logic captureHit;   // load the response register from the array
    logic invalidate;   // drop the addressed line before a refill
    logic bumpErr;      // count one detected parity error
    logic clearBeat;    // restart the fill beat counter
    logic fillWrite;    // write one fill beat into the line
    logic fillCommit;   // mark the refilled line valid with its tag
  } wtcStrobes_t;

endpackage

// File: rtl/wtc_parity.sv
module wtc_parity #(
  parameter int DATA_W = 32,
  localparam int BYTES = DATA_W / 8
) (
  input  logic [DATA_W-1:0] word,
  output logic [BYTES-1:0]  parity
);

  // Even parity: the parity bit makes each byte plus its bit hold an even count of ones.
  for (genvar b = 0; b < BYTES; b++) begin : g_byte
    assign parity[b] = ^word[8*b +: 8];
  end

endmodule

// File: rtl/wtc_datapath.sv
module wtc_datapath
  import wtc_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int LINES     = 16,
  parameter int WORDS     = 4,
  parameter int DATA_W    = 32,
  parameter int ERR_CNT_W = 8,
  localparam int IDX_W  = $clog2(LINES),
  localparam int OFF_W  = $clog2(WORDS),
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W,
  localparam int BYTES  = DATA_W / 8,
  localparam int BSEL_W = $clog2(BYTES)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  wtcStrobes_t          st,
  input  logic                 cpuReqWrite,
  input  logic [ADDR_W-1:0]    cpuReqAddr,
  input  logic [DATA_W-1:0]    cpuReqWdata,
  input  logic [DATA_W-1:0]    memRespData,
  input  logic                 faultValid,
  input  logic [IDX_W-1:0]     faultLine,
  input  logic [OFF_W-1:0]     faultWord,
  input  logic [BSEL_W-1:0]    faultByte,
  output logic                 reqWrite,
  output logic                 tagHit,
  output logic                 wordParityOk,
  output logic                 lastBeat,
  output logic [ADDR_W-1:0]    memReqAddr,
  output logic [DATA_W-1:0]    memReqWdata,
  output logic [DATA_W-1:0]    cpuRespRdata,
  output logic [ERR_CNT_W-1:0] errCount
);

  logic [ADDR_W-1:0] reqAddr;
  logic [DATA_W-1:0] reqWdata;

  logic [LINES-1:0]  lineValid;
  logic [TAG_W-1:0]  tagMem  [LINES];
  logic [DATA_W-1:0] dataMem [LINES][WORDS];
  logic [BYTES-1:0]  parMem  [LINES][WORDS];

  logic [OFF_W-1:0]  beatCnt;
  logic [DATA_W-1:0] respData;

  logic [TAG_W-1:0]  reqTag;
  logic [IDX_W-1:0]  reqIdx;
  logic [OFF_W-1:0]  reqOff;
  logic [DATA_W-1:0] rdWord;
  logic [BYTES-1:0]  rdPar;
  logic [BYTES-1:0]  calcPar;
  logic [DATA_W-1:0] wrData;
  logic [OFF_W-1:0]  wrOff;
  logic [BYTES-1:0]  wrPar;
  logic              arrayWrite;

  assign reqTag = reqAddr[ADDR_W-1 -: TAG_W];
  assign reqIdx = reqAddr[OFF_W +: IDX_W];
  assign reqOff = reqAddr[OFF_W-1:0];

  // Request capture
  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqAddr  <= '0;
      reqWdata <= '0;
      reqWrite <= 1'b0;
    end else if (st.latchReq) begin
      reqAddr  <= cpuReqAddr;
      reqWdata <= cpuReqWdata;
      reqWrite <= cpuReqWrite;
    end
  end

  // Lookup and parity check of the addressed word only
  assign rdWord = dataMem[reqIdx][reqOff];
  assign rdPar  = parMem[reqIdx][reqOff];

  wtc_parity #(.DATA_W(DATA_W)) u_chkPar (
    .word   (rdWord),
    .parity (calcPar)
  );

  assign tagHit       = lineValid[reqIdx] && (tagMem[reqIdx] == reqTag);
  assign wordParityOk = (calcPar == rdPar);

  // Array write path shared by store hits and fill beats
  assign arrayWrite = st.fillWrite || st.storeUpdate;
  assign wrData     = st.fillWrite ? memRespData : reqWdata;
  assign wrOff      = st.fillWrite ? beatCnt : reqOff;

  wtc_parity #(.DATA_W(DATA_W)) u_genPar (
    .word   (wrData),
    .parity (wrPar)
  );

  always_ff @(posedge clk) begin
    if (arrayWrite) begin
      dataMem[reqIdx][wrOff] <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (arrayWrite) begin
      parMem[reqIdx][wrOff] <= wrPar;
    end else if (faultValid) begin
      parMem[faultLine][faultWord][faultByte] <= ~parMem[faultLine][faultWord][faultByte];
    end
  end

  always_ff @(posedge clk) begin
    if (st.fillCommit) begin
      tagMem[reqIdx] <= reqTag;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineValid <= '0;
    end else if (st.fillCommit) begin
      lineValid[reqIdx] <= 1'b1;
    end else if (st.invalidate) begin
      lineValid[reqIdx] <= 1'b0;
    end
  end

  // Fill beat counter
  assign lastBeat = (beatCnt == OFF_W'(WORDS - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      beatCnt <= '0;
    end else if (st.clearBeat) begin
      beatCnt <= '0;
    end else if (st.fillWrite) begin
      beatCnt <= beatCnt + 1'b1;
    end
  end

  // Response data: array word on a hit, matching beat on a fill
  always_ff @(posedge clk) begin
    if (!rstN) begin
      respData <= '0;
    end else if (st.captureHit) begin
      respData <= rdWord;
    end else if (st.fillWrite && (beatCnt == reqOff)) begin
      respData <= memRespData;
    end
  end

  assign cpuRespRdata = respData;

  // Saturating parity-error counter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      errCount <= '0;
    end else if (st.bumpErr && (errCount != {ERR_CNT_W{1'b1}})) begin
      errCount <= errCount + 1'b1;
    end
  end

  // Next-level request fields
  assign memReqAddr  = reqWrite ? reqAddr : {reqAddr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  assign memReqWdata = reqWdata;

endmodule

// File: rtl/wtc_ctrl.sv
module wtc_ctrl
  import wtc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cpuReqValid,
  input  logic        memReqReady,
  input  logic        memRespValid,
  input  logic        reqWrite,
  input  logic        tagHit,
  input  logic        wordParityOk,
  input  logic        lastBeat,
  output logic        cpuReqReady,
  output logic        cpuRespValid,
  output logic        memReqValid,
  output logic        memReqWrite,
  output wtcStrobes_t st
);

  wtcState_e state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
    end else begin
      state <= stateNext;
    end
  end

  always_comb begin
    stateNext    = state;
    st           = '0;
    cpuReqReady  = 1'b0;
    cpuRespValid = 1'b0;
    memReqValid  = 1'b0;
    memReqWrite  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        cpuReqReady = 1'b1;
        if (cpuReqValid) begin
          st.latchReq = 1'b1;
          stateNext   = ST_LOOKUP;
        end
      end
      ST_LOOKUP: begin
        if (reqWrite) begin
          st.storeUpdate = tagHit;
          stateNext      = ST_WR_REQ;
        end else if (tagHit && wordParityOk) begin
          st.captureHit = 1'b1;
          stateNext     = ST_RESP;
        end else begin
          st.bumpErr    = tagHit;
          st.invalidate = 1'b1;
          st.clearBeat  = 1'b1;
          stateNext     = ST_FILL_REQ;
        end
      end
      ST_WR_REQ: begin
        memReqValid = 1'b1;
        memReqWrite = 1'b1;
        if (memReqReady) begin
          stateNext = ST_RESP;
        end
      end
      ST_FILL_REQ: begin
        memReqValid = 1'b1;
        if (memReqReady) begin
          stateNext = ST_FILL_WAIT;
        end
      end
      ST_FILL_WAIT: begin
        if (memRespValid) begin
          st.fillWrite = 1'b1;
          if (lastBeat) begin
            st.fillCommit = 1'b1;
            stateNext     = ST_RESP;
          end
        end
      end
      ST_RESP: begin
        cpuRespValid = 1'b1;
        stateNext    = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/wt_parity_cache.sv
module wt_parity_cache
  import wtc_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int LINES     = 16,
  parameter int WORDS     = 4,
  parameter int DATA_W    = 32,
  parameter int ERR_CNT_W = 8,
  localparam int IDX_W  = $clog2(LINES),
  localparam int OFF_W  = $clog2(WORDS),
  localparam int BSEL_W = $clog2(DATA_W / 8)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cpuReqValid,
  output logic                 cpuReqReady,
  input  logic                 cpuReqWrite,
  input  logic [ADDR_W-1:0]    cpuReqAddr,
  input  logic [DATA_W-1:0]    cpuReqWdata,
  output logic                 cpuRespValid,
  output logic [DATA_W-1:0]    cpuRespRdata,
  output logic                 memReqValid,
  input  logic                 memReqReady,
  output logic                 memReqWrite,
  output logic [ADDR_W-1:0]    memReqAddr,
  output logic [DATA_W-1:0]    memReqWdata,
  input  logic                 memRespValid,
  input  logic [DATA_W-1:0]    memRespData,
  input  logic                 faultValid,
  input  logic [IDX_W-1:0]     faultLine,
  input  logic [OFF_W-1:0]     faultWord,
  input  logic [BSEL_W-1:0]    faultByte,
  output logic [ERR_CNT_W-1:0] errCount
);

  wtcStrobes_t st;
  logic reqWrite;
  logic tagHit;
  logic wordParityOk;
  logic lastBeat;

  wtc_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .cpuReqValid  (cpuReqValid),
    .memReqReady  (memReqReady),
    .memRespValid (memRespValid),
    .reqWrite     (reqWrite),
    .tagHit       (tagHit),
    .wordParityOk (wordParityOk),
    .lastBeat     (lastBeat),
    .cpuReqReady  (cpuReqReady),
    .cpuRespValid (cpuRespValid),
    .memReqValid  (memReqValid),
    .memReqWrite  (memReqWrite),
    .st           (st)
  );

  wtc_datapath #(
    .ADDR_W    (ADDR_W),
    .LINES     (LINES),
    .WORDS     (WORDS),
    .DATA_W    (DATA_W),
    .ERR_CNT_W (ERR_CNT_W)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .st           (st),
    .cpuReqWrite  (cpuReqWrite),
    .cpuReqAddr   (cpuReqAddr),
    .cpuReqWdata  (cpuReqWdata),
    .memRespData  (memRespData),
    .faultValid   (faultValid),
    .faultLine    (faultLine),
    .faultWord    (faultWord),
    .faultByte    (faultByte),
    .reqWrite     (reqWrite),
    .tagHit       (tagHit),
    .wordParityOk (wordParityOk),
    .lastBeat     (lastBeat),
    .memReqAddr   (memReqAddr),
    .memReqWdata  (memReqWdata),
    .cpuRespRdata (cpuRespRdata),
    .errCount     (errCount)
  );

endmodule

// File: rtl/wtc_checker.sv
module wtc_checker #(
  parameter int ADDR_W    = 16,
  parameter int WORDS     = 4,
  parameter int DATA_W    = 32,
  parameter int ERR_CNT_W = 8,
  localparam int OFF_W = $clog2(WORDS)
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 cpuReqValid,
  input logic                 cpuReqReady,
  input logic                 cpuReqWrite,
  input logic [DATA_W-1:0]    cpuReqWdata,
  input logic                 cpuRespValid,
  input logic                 memReqValid,
  input logic                 memReqReady,
  input logic                 memReqWrite,
  input logic [ADDR_W-1:0]    memReqAddr,
  input logic [DATA_W-1:0]    memReqWdata,
  input logic [ERR_CNT_W-1:0] errCount
);

  logic              pendWrite;
  logic [DATA_W-1:0] pendData;
  logic              fillSeen;
  logic              cpuAccept;
  logic              fillHs;

  assign cpuAccept = cpuReqValid && cpuReqReady;
  assign fillHs    = memReqValid && memReqReady && !memReqWrite;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendWrite <= 1'b0;
      pendData  <= '0;
      fillSeen  <= 1'b0;
    end else if (cpuAccept) begin
      pendWrite <= cpuReqWrite;
      pendData  <= cpuReqWdata;
      fillSeen  <= 1'b0;
    end else if (fillHs) begin
      fillSeen  <= 1'b1;
    end
  end

  p_resp_pulse_r2: assert property (@(posedge clk) disable iff (!rstN)
    cpuRespValid |=> !cpuRespValid);

  p_fill_aligned_r3: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqWrite) |-> (memReqAddr[OFF_W-1:0] == '0));

  p_single_fill_r4: assert property (@(posedge clk) disable iff (!rstN)
    fillHs |-> !fillSeen);

  p_no_wb_r4: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && memReqWrite) |-> pendWrite);

  p_store_data_r5: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && memReqWrite) |-> (memReqWdata == pendData));

  p_req_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=>
      (memReqValid && $stable(memReqAddr) && $stable(memReqWrite)));

  p_count_step_r11: assert property (@(posedge clk) disable iff (!rstN)
    (errCount != $past(errCount)) |-> (errCount == $past(errCount) + 1'b1));

  p_ready_idle_r12: assert property (@(posedge clk) disable iff (!rstN)
    cpuReqReady |-> (!memReqValid && !cpuRespValid));

endmodule

bind wt_parity_cache wtc_checker #(
  .ADDR_W    (ADDR_W),
  .WORDS     (WORDS),
  .DATA_W    (DATA_W),
  .ERR_CNT_W (ERR_CNT_W)
) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .cpuReqValid  (cpuReqValid),
  .cpuReqReady  (cpuReqReady),
  .cpuReqWrite  (cpuReqWrite),
  .cpuReqWdata  (cpuReqWdata),
  .cpuRespValid (cpuRespValid),
  .memReqValid  (memReqValid),
  .memReqReady  (memReqReady),
  .memReqWrite  (memReqWrite),
  .memReqAddr   (memReqAddr),
  .memReqWdata  (memReqWdata),
  .errCount     (errCount)
);

// File: tb/wt_parity_cache_test.sv
module wt_parity_cache_test;

  localparam int ADDR_W = 10;
  localparam int LINES  = 16;
  localparam int WORDS  = 4;
  localparam int DATA_W = 32;
  localparam int ECW    = 3;
  localparam int ERRMAX = (1 << ECW) - 1;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              cpuReqValid = 1'b0;
  logic              cpuReqReady;
  logic              cpuReqWrite = 1'b0;
  logic [ADDR_W-1:0] cpuReqAddr = '0;
  logic [DATA_W-1:0] cpuReqWdata = '0;
  logic              cpuRespValid;
  logic [DATA_W-1:0] cpuRespRdata;
  logic              memReqValid;
  logic              memReqReady = 1'b0;
  logic              memReqWrite;
  logic [ADDR_W-1:0] memReqAddr;
  logic [DATA_W-1:0] memReqWdata;
  logic              memRespValid = 1'b0;
  logic [DATA_W-1:0] memRespData = '0;
  logic              faultValid = 1'b0;
  logic [3:0]        faultLine = '0;
  logic [1:0]        faultWord = '0;
  logic [1:0]        faultByte = '0;
  logic [ECW-1:0]    errCount;

  always #10 clk = ~clk;  // 50 MHz

  wt_parity_cache #(
    .ADDR_W(ADDR_W), .LINES(LINES), .WORDS(WORDS), .DATA_W(DATA_W), .ERR_CNT_W(ECW)
  ) uut (
    .clk(clk), .rstN(rstN),
    .cpuReqValid(cpuReqValid), .cpuReqReady(cpuReqReady), .cpuReqWrite(cpuReqWrite),
    .cpuReqAddr(cpuReqAddr), .cpuReqWdata(cpuReqWdata),
    .cpuRespValid(cpuRespValid), .cpuRespRdata(cpuRespRdata),
    .memReqValid(memReqValid), .memReqReady(memReqReady), .memReqWrite(memReqWrite),
    .memReqAddr(memReqAddr), .memReqWdata(memReqWdata),
    .memRespValid(memRespValid), .memRespData(memRespData),
    .faultValid(faultValid), .faultLine(faultLine), .faultWord(faultWord),
    .faultByte(faultByte), .errCount(errCount)
  );

  int tests = 0;
  int fails = 0;

  // Behavioural reference: next-level memory plus expected cache directory
  logic [DATA_W-1:0] mem [1 << ADDR_W];
  bit                mV [LINES];
  logic [3:0]        mT [LINES];
  logic [3:0]        mFlip [LINES][WORDS];
  int                expErr = 0;

  int                memDelay = 0;
  int                fillCount = 0;
  int                writeCount = 0;
  logic [ADDR_W-1:0] lastFillAddr = '0;
  logic [ADDR_W-1:0] lastWA = '0;
  logic [DATA_W-1:0] lastWD = '0;
  bit                busy = 0;
  bit                busyAcc = 0;
  bit                curWrite = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Next-level memory responder
  initial begin
    forever begin
      @(negedge clk);
      if (memReqValid) begin
        repeat (memDelay) @(negedge clk);
        memReqReady = 1'b1;
        if (memReqWrite) begin
          mem[memReqAddr] = memReqWdata;
          writeCount++;
          lastWA = memReqAddr;
          lastWD = memReqWdata;
          @(negedge clk);
          memReqReady = 1'b0;
        end else begin
          logic [ADDR_W-1:0] base;
          base = memReqAddr;
          fillCount++;
          lastFillAddr = base;
          @(negedge clk);
          memReqReady = 1'b0;
          repeat (memDelay) @(negedge clk);
          for (int b = 0; b < WORDS; b++) begin
            memRespValid = 1'b1;
            memRespData  = mem[base + ADDR_W'(b)];
            @(negedge clk);
          end
          memRespValid = 1'b0;
        end
      end
    end
  end

  // Per-clock comparison against the bench's view of the access in flight
  always @(posedge clk) begin
    #5;
    if (rstN) begin
      if (busyAcc) check(cpuReqReady == 1'b0, "R12 ready low in flight", cpuReqReady, 0);
      if (memReqValid) check(busy, "R4 no unsolicited next-level request", 0, 1);
      if (memReqValid && memReqWrite) check(curWrite, "R4 write only for a store", 0, 1);
    end
  end

  task automatic access(input bit w, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                        output logic [DATA_W-1:0] r, output int lat);
    @(negedge clk);
    check(cpuReqReady == 1'b1, "R12 ready when idle", cpuReqReady, 1);
    cpuReqValid = 1'b1;
    cpuReqWrite = w;
    cpuReqAddr  = a;
    cpuReqWdata = d;
    busy = 1;
    curWrite = w;
    @(negedge clk);
    cpuReqValid = 1'b0;
    busyAcc = 1;
    lat = 1;
    while (!cpuRespValid) begin
      @(negedge clk);
      lat++;
    end
    r = cpuRespRdata;
    busyAcc = 0;
    busy = 0;
  endtask

  task automatic doRead(input logic [ADDR_W-1:0] a, input string req);
    logic [3:0] ln, tg;
    logic [1:0] wd;
    bit hitTag, bad, expFill;
    int f0, w0, lat;
    logic [DATA_W-1:0] r;
    ln = a[5:2]; tg = a[9:6]; wd = a[1:0];
    hitTag  = mV[ln] && (mT[ln] == tg);
    bad     = (mFlip[ln][wd] != 0);
    expFill = !(hitTag && !bad);
    if (hitTag && bad && expErr < ERRMAX) expErr++;
    f0 = fillCount; w0 = writeCount;
    access(1'b0, a, '0, r, lat);
    check(r == mem[a], {req, " load data"}, r, mem[a]);
    check((fillCount - f0) == int'(expFill), {req, " fill count"}, fillCount - f0, expFill);
    check(writeCount == w0, "R4 load issues no write", writeCount - w0, 0);
    check(int'(errCount) == expErr, {req, " error count"}, errCount, expErr);
    if (expFill) begin
      check(lastFillAddr == {a[9:2], 2'b00}, "R3 fill address aligned", lastFillAddr, {a[9:2], 2'b00});
      mV[ln] = 1; mT[ln] = tg;
      for (int k = 0; k < WORDS; k++) mFlip[ln][k] = '0;
    end else begin
      check(lat == 2, "R2 hit latency", lat, 2);
    end
  endtask

  task automatic doWrite(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d, input string req);
    logic [3:0] ln;
    int f0, w0, lat;
    logic [DATA_W-1:0] r;
    ln = a[5:2];
    f0 = fillCount; w0 = writeCount;
    access(1'b1, a, d, r, lat);
    check((writeCount - w0) == 1, {req, " one write"}, writeCount - w0, 1);
    check(lastWA == a, "R5 write address", lastWA, a);
    check(lastWD == d, "R5 write data", lastWD, d);
    check(fillCount == f0, "R7 store issues no fill", fillCount - f0, 0);
    if (mV[ln] && mT[ln] == a[9:6]) mFlip[ln][a[1:0]] = '0;
  endtask

  task automatic inject(input logic [3:0] ln, input logic [1:0] wd, input logic [1:0] by);
    @(negedge clk);
    faultValid = 1'b1; faultLine = ln; faultWord = wd; faultByte = by;
    @(negedge clk);
    faultValid = 1'b0;
    mFlip[ln][wd][by] = ~mFlip[ln][wd][by];
  endtask

  initial begin
    logic [15:0] lfsr;
    for (int i = 0; i < (1 << ADDR_W); i++) mem[i] = (32'(i) * 32'h9E3779B1) ^ 32'hC0DE0000;
    for (int i = 0; i < LINES; i++) begin
      mV[i] = 0; mT[i] = '0;
      for (int k = 0; k < WORDS; k++) mFlip[i][k] = '0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(cpuReqReady == 1'b1, "R1 reset ready", cpuReqReady, 1);
    check(cpuRespValid == 1'b0, "R1 reset resp", cpuRespValid, 0);
    check(memReqValid == 1'b0, "R1 reset mem req", memReqValid, 0);
    check(errCount == '0, "R1 reset count", errCount, 0);

    // Cold miss, then hits within the line
    doRead(10'h000, "R1 cold miss");
    doRead(10'h001, "R2 hit");
    doRead(10'h003, "R2 hit");
    doRead(10'h002, "R2 hit");
    // Conflict replacement without writeback
    doRead(10'h041, "R3 conflict miss");
    doRead(10'h002, "R4 replace back");
    // Slower next level
    memDelay = 2;
    doRead(10'h017, "R3 miss slow memory");
    doRead(10'h014, "R2 hit");
    memDelay = 1;
    // Store hit then read back
    doWrite(10'h001, 32'hDEADBEEF, "R5 store hit");
    doRead(10'h001, "R6 read after store hit");
    // Store miss does not allocate
    doWrite(10'h3F5, 32'h12345678, "R5 store miss");
    doRead(10'h3F5, "R7 read after store miss");
    // Parity fault in another word of the line
    inject(4'd0, 2'd2, 2'd1);
    doRead(10'h000, "R9 fault elsewhere in line");
    doRead(10'h002, "R8 fault detected");
    doRead(10'h002, "R8 hit after refill");
    // Store hit clears a fault in its word
    inject(4'd0, 2'd3, 2'd0);
    doWrite(10'h003, 32'hA5A5F00F, "R10 store over fault");
    doRead(10'h003, "R10 clean after store");
    // Double inversion restores parity
    inject(4'd0, 2'd1, 2'd3);
    inject(4'd0, 2'd1, 2'd3);
    doRead(10'h001, "R8 double flip");
    // Counter saturation
    memDelay = 0;
    doRead(10'h015, "R3 setup line");
    for (int i = 0; i < 9; i++) begin
      inject(4'd5, 2'd1, 2'(i));
      doRead(10'h015, "R11 saturate");
    end
    check(int'(errCount) == ERRMAX, "R11 saturated", errCount, ERRMAX);

    // Mixed pattern
    lfsr = 16'hACE1;
    for (int i = 0; i < 300; i++) begin
      logic [ADDR_W-1:0] a;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      a = {2'b00, lfsr[7:0]};
      memDelay = int'(lfsr[10:9]);
      if (lfsr[11] && lfsr[12]) inject(lfsr[5:2], lfsr[1:0], lfsr[14:13]);
      if (lfsr[15]) doWrite(a, {lfsr, ~lfsr}, "R5 mixed store");
      else doRead(a, "R3 mixed load");
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule